// File: doc/BRIEF.md
# Short Floating-Point Adder/Subtractor

This block adds or subtracts two numbers held in a compact 22-bit floating-point word. The word has a sign, a 7-bit biased exponent and a 14-bit fraction behind an implied leading one. Every finite result leaves the block normalized. Signed infinities are accepted as operands and can be produced as results. An undefined value has its own encoding and is returned for operations that have no meaningful answer. Bits that drop off during alignment or normalization are truncated. The block does not round, and it does not support gradual underflow.

The block is a two-stage pipeline with a valid/ready handshake on each side. Stage one classifies the operands, settles the special cases, orders the operands by magnitude and aligns the smaller one. Stage two adds or subtracts the significands, normalizes the result and packs it into the registered output. When the output is stalled, results are held and back-pressure reaches the input.

Top module: `fpa22_adder`

## Requirements
- R1: The word layout is sign in bit 21, exponent in bits 20:14 biased by 63, and fraction in bits 13:0 with a hidden leading one (1.0 = 0x0FC000, 2.0 = 0x100000).
- R2: An operand whose exponent field is 0 is treated as zero whatever its fraction bits hold. Every zero result is emitted as the all-zero word 0x000000.
- R3: When in_sub is 1 the result is in_a minus in_b. This is done by inverting the sign of in_b before the add.
- R4: The operand with the smaller magnitude has its significand shifted right by the exponent difference. The shifted-out bits are discarded before the add. When the magnitudes are equal, in_a is taken as the larger.
- R5: A finite nonzero result has an exponent field between 1 and 126. Its fraction is the truncated significand, normalized to a leading one.
- R6: If the exponent after normalization reaches 127 or more, the result is an infinity (0x1FC000 or 0x3FC000) carrying the sign of the larger operand.
- R7: If the exponent after normalization is 0 or below, the result is flushed to 0x000000.
- R8: An infinity combined with a finite value gives that infinity, with its effective sign. Two infinities with the same effective sign give that infinity.
- R9: If any operand is undefined (exponent 127 with a nonzero fraction), or two infinities have opposite effective signs, the result is the canonical undefined word 0x1FC001.
- R10: Operands are accepted on a clock edge where in_valid and in_ready are both high. If the output is not stalled, the result is shown with out_valid on the next edge after acceptance. Results come out in acceptance order.
- R11: While out_valid is high and out_ready is low, out_valid and out_data stay unchanged. in_ready drops once both stages hold a result. in_ready is high whenever out_valid is low.
- R12: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Block can take an operand pair |
| in_a | input | 22 | First operand |
| in_b | input | 22 | Second operand |
| in_sub | input | 1 | 1 selects in_a minus in_b |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 22 | Result word |

## Verification
Most internal faults surface in out_data on the very result they affect, one edge after that operand pair is accepted. Examples are a wrong swap decision, a misaligned significand, or an off-by-one in the leading-zero count or exponent adjust. Such faults show up as a wrong fraction or an exponent one step off. Faults in the special-case logic show up as a finite word where an infinity or the undefined word belongs, or the reverse. A broken valid/ready chain shows up as lost, duplicated or reordered results, or as data changing during a stall, within a cycle or two of the stall.

// File: rtl/fpa22_pkg.sv
package fpa22_pkg;
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fp_cls_e;
endpackage

// File: rtl/fpa22_classify.sv
module fpa22_classify
  import fpa22_pkg::*;
#(
  parameter int EXP_W  = 7,
  parameter int FRAC_W = 14,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word_i,
  output fp_cls_e           cls_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [FRAC_W:0]   mant_o
);
  logic [EXP_W-1:0]  fld_e;
  logic [FRAC_W-1:0] fld_f;

  assign fld_e = word_i[WORD_W-2 -: EXP_W];
  assign fld_f = word_i[FRAC_W-1:0];

  always_comb begin
    if (fld_e == '1)      cls_o = (fld_f == '0) ? CLS_INF : CLS_NAN;
    else if (fld_e == '0) cls_o = CLS_ZERO;
    else                  cls_o = CLS_NORM;
    // zero and denormal patterns collapse to a true zero
    exp_o  = (cls_o == CLS_NORM) ? fld_e : '0;
    mant_o = (cls_o == CLS_NORM) ? {1'b1, fld_f} : '0;
  end
endmodule

// File: rtl/fpa22_align.sv
module fpa22_align
  import fpa22_pkg::*;
#(
  parameter int EXP_W  = 7,
  parameter int FRAC_W = 14,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              sub_i,
  output logic              spec_o,
  output logic [WORD_W-1:0] spec_word_o,
  output logic              sign_o,
  output logic              eff_sub_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [FRAC_W:0]   big_o,
  output logic [FRAC_W:0]   small_o
);
  localparam logic [WORD_W-1:0] NAN_WORD = {1'b0, {EXP_W{1'b1}}, {(FRAC_W-1){1'b0}}, 1'b1};

  logic [WORD_W-1:0] opw [2];
  logic              sgn [2];
  fp_cls_e           cls [2];
  logic [EXP_W-1:0]  ex  [2];
  logic [FRAC_W:0]   mt  [2];

  assign opw[0] = a_i;
  assign opw[1] = b_i;
  assign sgn[0] = a_i[WORD_W-1];
  assign sgn[1] = b_i[WORD_W-1] ^ sub_i;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fpa22_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word_i (opw[g]),
      .cls_o  (cls[g]),
      .exp_o  (ex[g]),
      .mant_o (mt[g])
    );
  end

  function automatic logic [WORD_W-1:0] inf_word(input logic s);
    return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  endfunction

  always_comb begin
    spec_o      = 1'b1;
    spec_word_o = NAN_WORD;
    if (cls[0] == CLS_NAN || cls[1] == CLS_NAN) begin
      spec_word_o = NAN_WORD;
    end else if (cls[0] == CLS_INF && cls[1] == CLS_INF) begin
      spec_word_o = (sgn[0] == sgn[1]) ? inf_word(sgn[0]) : NAN_WORD;
    end else if (cls[0] == CLS_INF) begin
      spec_word_o = inf_word(sgn[0]);
    end else if (cls[1] == CLS_INF) begin
      spec_word_o = inf_word(sgn[1]);
    end else begin
      spec_o = 1'b0;
    end
  end

  logic             a_big;
  logic [EXP_W-1:0] diff;
  logic [FRAC_W:0]  sm_raw;

  always_comb begin
    a_big     = {ex[0], mt[0][FRAC_W-1:0]} >= {ex[1], mt[1][FRAC_W-1:0]};
    sign_o    = a_big ? sgn[0] : sgn[1];
    eff_sub_o = sgn[0] ^ sgn[1];
    exp_o     = a_big ? ex[0] : ex[1];
    big_o     = a_big ? mt[0] : mt[1];
    sm_raw    = a_big ? mt[1] : mt[0];
    diff      = a_big ? (ex[0] - ex[1]) : (ex[1] - ex[0]);
    small_o   = sm_raw >> diff;
  end
endmodule

// File: rtl/fpa22_addnorm.sv
module fpa22_addnorm #(
  parameter int EXP_W  = 7,
  parameter int FRAC_W = 14,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int MW     = FRAC_W + 1,
  localparam int LZW    = $clog2(MW + 1),
  localparam int EW     = EXP_W + 2
) (
  input  logic              sign_i,
  input  logic              sub_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W:0]   big_i,
  input  logic [FRAC_W:0]   small_i,
  output logic [WORD_W-1:0] word_o
);
  localparam logic signed [EW-1:0] EMAX = $signed({2'b00, {EXP_W{1'b1}}});

  logic [MW:0]            sum;
  logic [LZW-1:0]         lz;
  logic signed [EW-1:0]   e_base;
  logic signed [EW-1:0]   e_n;
  logic [MW-1:0]          m_n;

  always_comb begin
    sum = sub_i ? ({1'b0, big_i} - {1'b0, small_i}) : ({1'b0, big_i} + {1'b0, small_i});
    lz  = LZW'(MW);
    for (int i = 0; i < MW; i++) begin
      if (sum[i]) lz = LZW'(MW - 1 - i);
    end
  end

  always_comb begin
    e_base = $signed({2'b00, exp_i});
    if (sum[MW]) begin
      e_n = e_base + EW'(1);
      m_n = sum[MW:1];
    end else begin
      e_n = e_base - $signed(EW'(lz));
      m_n = sum[MW-1:0] << lz;
    end
  end

  always_comb begin
    if (sum == '0)                      word_o = '0;
    else if (e_n >= EMAX)               word_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (e_n <= $signed(EW'(0)))    word_o = '0;
    else                                word_o = {sign_i, e_n[EXP_W-1:0], m_n[FRAC_W-1:0]};
  end
endmodule

// File: rtl/fpa22_adder.sv
module fpa22_adder #(
  parameter int EXP_W  = 7,
  parameter int FRAC_W = 14,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic              in_sub,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  localparam logic [WORD_W-1:0] NAN_WORD = {1'b0, {EXP_W{1'b1}}, {(FRAC_W-1){1'b0}}, 1'b1};

  // stage one combinational results
  logic              c_spec, c_sign, c_sub;
  logic [WORD_W-1:0] c_spec_w;
  logic [EXP_W-1:0]  c_exp;
  logic [FRAC_W:0]   c_big, c_small;

  fpa22_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .a_i         (in_a),
    .b_i         (in_b),
    .sub_i       (in_sub),
    .spec_o      (c_spec),
    .spec_word_o (c_spec_w),
    .sign_o      (c_sign),
    .eff_sub_o   (c_sub),
    .exp_o       (c_exp),
    .big_o       (c_big),
    .small_o     (c_small)
  );

  // stage one registers
  logic              s1_v, s1_spec, s1_sign, s1_sub;
  logic [WORD_W-1:0] s1_spec_w;
  logic [EXP_W-1:0]  s1_exp;
  logic [FRAC_W:0]   s1_big, s1_small;
  logic [WORD_W-1:0] n_word;

  fpa22_addnorm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_addnorm (
    .sign_i  (s1_sign),
    .sub_i   (s1_sub),
    .exp_i   (s1_exp),
    .big_i   (s1_big),
    .small_i (s1_small),
    .word_o  (n_word)
  );

  logic out_adv, s1_adv;
  assign out_adv  = !out_valid || out_ready;
  assign s1_adv   = !s1_v || out_adv;
  assign in_ready = s1_adv;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      if (s1_adv)  s1_v      <= in_valid;
      if (out_adv) out_valid <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_adv) begin
      s1_spec   <= c_spec;
      s1_spec_w <= c_spec_w;
      s1_sign   <= c_sign;
      s1_sub    <= c_sub;
      s1_exp    <= c_exp;
      s1_big    <= c_big;
      s1_small  <= c_small;
    end
    if (out_adv) out_data <= s1_spec ? s1_spec_w : n_word;
  end

  // R11
  hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R11
  ready_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R2
  zero_enc_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_data[WORD_W-2 -: EXP_W] == '0) |-> (out_data == '0));

  // R9
  nan_canon_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_data[WORD_W-2 -: EXP_W] == '1 && out_data[FRAC_W-1:0] != '0)
      |-> (out_data == NAN_WORD));

  // R4
  align_order_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_v && !s1_spec) |-> (s1_small <= s1_big));
endmodule

// File: tb/tb_fpa22_adder.sv
module tb_fpa22_adder;
  localparam int CLK_PERIOD = 10;
  localparam logic [21:0] NAN_W = 22'h1FC001;
  localparam logic [21:0] PINF  = 22'h1FC000;
  localparam logic [21:0] NINF  = 22'h3FC000;
  localparam logic [21:0] ONE   = 22'h0FC000;

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0, in_sub = 0, out_ready = 0;
  logic [21:0] in_a = 0, in_b = 0;
  logic in_ready, out_valid;
  logic [21:0] out_data;

  fpa22_adder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_sub(in_sub),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [21:0] exp_q [1024];
  string       tag_q [1024];
  int wr = 0, rd = 0;

  task automatic chk(input string req, input logic [21:0] act, input logic [21:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%06h expected=%06h", req, act, expv);
    end
  endtask

  function automatic logic [21:0] ref_add(input logic [21:0] a, input logic [21:0] b, input logic s);
    int ea, eb, fa, fb, ma, mb, ka, kb, eB, eS, mB, mS, sum, e, d;
    logic sa, sb, sB;
    sa = a[21]; sb = b[21] ^ s;
    ea = int'(a[20:14]); eb = int'(b[20:14]);
    fa = int'(a[13:0]);  fb = int'(b[13:0]);
    if ((ea == 127 && fa != 0) || (eb == 127 && fb != 0)) return NAN_W;
    if (ea == 127 && eb == 127) return (sa == sb) ? {sa, 7'h7F, 14'h0} : NAN_W;
    if (ea == 127) return {sa, 7'h7F, 14'h0};
    if (eb == 127) return {sb, 7'h7F, 14'h0};
    if (ea == 0) begin ma = 0; fa = 0; end else ma = 16384 + fa;
    if (eb == 0) begin mb = 0; fb = 0; end else mb = 16384 + fb;
    ka = ea * 16384 + fa; kb = eb * 16384 + fb;
    if (ka >= kb) begin eB = ea; mB = ma; sB = sa; eS = eb; mS = mb; end
    else          begin eB = eb; mB = mb; sB = sb; eS = ea; mS = ma; end
    d = eB - eS;
    mS = (d >= 31) ? 0 : (mS >> d);
    sum = (sa != sb) ? mB - mS : mB + mS;
    if (sum == 0) return 22'h0;
    e = eB;
    while (sum >= 32768) begin sum = sum >> 1; e++; end
    while (sum < 16384)  begin sum = sum << 1; e--; end
    if (e >= 127) return {sB, 7'h7F, 14'h0};
    if (e <= 0) return 22'h0;
    return {sB, 7'(e), 14'(sum & 16383)};
  endfunction

  // one cycle: entered just after a falling edge, left at the next falling edge
  task automatic cycle(input logic iv, input logic [21:0] a, input logic [21:0] b,
                       input logic s, input logic ordy, input string tag, output bit took);
    in_valid = iv; in_a = a; in_b = b; in_sub = s; out_ready = ordy;
    #1;
    took = iv && in_ready;
    if (out_valid && out_ready) begin
      if (rd == wr) begin
        checks++; errors++;
        $display("FAIL R10 actual=%06h expected=none (unexpected result)", out_data);
      end else begin
        chk(tag_q[rd % 1024], out_data, exp_q[rd % 1024]);
        rd++;
      end
    end
    if (took) begin
      exp_q[wr % 1024] = ref_add(a, b, s);
      tag_q[wr % 1024] = tag;
      wr++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [21:0] a, input logic [21:0] b, input logic s, input string tag);
    bit took;
    took = 0;
    while (!took) cycle(1'b1, a, b, s, ($urandom % 4) != 0, tag, took);
  endtask

  task automatic drain();
    bit took;
    for (int i = 0; i < 50 && rd != wr; i++) cycle(1'b0, '0, '0, 1'b0, 1'b1, "", took);
  endtask

  function automatic logic [21:0] rnd_word();
    int e, k;
    k = $urandom % 16;
    if (k == 0) e = 127;
    else if (k == 1) e = 0;
    else if (k == 2) e = (($urandom % 2) != 0) ? 126 : 1;
    else e = 50 + ($urandom % 28);
    return {1'($urandom), 7'(e), 14'($urandom)};
  endfunction

  initial begin
    bit took;
    logic [21:0] held;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R12 reset state
    checks++; if (out_valid !== 1'b0) begin errors++; $display("FAIL R12 actual=%0b expected=0 out_valid", out_valid); end
    checks++; if (in_ready !== 1'b1) begin errors++; $display("FAIL R12 actual=%0b expected=1 in_ready", in_ready); end

    // R10 latency: accept, then result after the next edge
    cycle(1'b1, ONE, ONE, 1'b0, 1'b1, "R1 R10 1+1", took);
    checks++; if (out_valid !== 1'b0) begin errors++; $display("FAIL R10 actual=%0b expected=0 early valid", out_valid); end
    cycle(1'b0, '0, '0, 1'b0, 1'b1, "", took);
    checks++; if (out_valid !== 1'b1) begin errors++; $display("FAIL R10 actual=%0b expected=1 valid after one edge", out_valid); end
    chk("R1 2.0", out_data, 22'h100000);
    drain();

    // directed corners
    send(ONE, ONE, 1'b1, "R3 1-1");
    send(22'h100000, ONE, 1'b1, "R3 2-1");
    send(ONE, 22'h0F8001, 1'b0, "R4 truncate");
    send(ONE, 22'h0C0003, 1'b1, "R4 truncate sub");
    send(ONE, 22'h0FC000 | 22'h200000, 1'b0, "R4 equal mag opposite");
    send(22'h000123, ONE, 1'b0, "R2 denormal as zero");
    send(22'h000000, 22'h200000, 1'b0, "R2 zero plus neg zero");
    send(22'h0FFFFF, 22'h0FC001, 1'b1, "R5 cancel");
    send(22'h1FBFFF, 22'h1FBFFF, 1'b0, "R6 overflow pos");
    send(22'h3FBFFF, 22'h1FBFFF, 1'b1, "R6 overflow neg");
    send(22'h004001, 22'h004000, 1'b1, "R7 underflow");
    send(PINF, ONE, 1'b0, "R8 inf plus finite");
    send(ONE, PINF, 1'b1, "R8 finite minus inf");
    send(NINF, NINF, 1'b0, "R8 same inf");
    send(PINF, PINF, 1'b1, "R9 inf minus inf");
    send(PINF, NINF, 1'b0, "R9 opposite inf");
    send(22'h1FC123, ONE, 1'b0, "R9 nan in");
    send(NINF, 22'h3FC001, 1'b0, "R9 nan with inf");
    drain();

    // R11 stall: fill both stages with out_ready low
    cycle(1'b1, ONE, ONE, 1'b0, 1'b0, "R11 stall a", took);
    cycle(1'b1, ONE, 22'h100000, 1'b0, 1'b0, "R11 stall b", took);
    checks++; if (in_ready !== 1'b0) begin errors++; $display("FAIL R11 actual=%0b expected=0 in_ready when full", in_ready); end
    held = out_data;
    cycle(1'b1, ONE, ONE, 1'b1, 1'b0, "R11 stall c", took);
    checks++; if (took) begin errors++; $display("FAIL R11 actual=1 expected=0 accepted while full"); end
    chk("R11 held data", out_data, held);
    checks++; if (out_valid !== 1'b1) begin errors++; $display("FAIL R11 actual=%0b expected=1 held valid", out_valid); end
    drain();

    // random mix
    for (int i = 0; i < 600; i++) send(rnd_word(), rnd_word(), 1'($urandom), "R5 R10 random");
    drain();
    chk("R10 all results returned", 22'(wr - rd), 22'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule